// File: doc/BRIEF.md
# Three-Stage Register Pipeline with Result Bypass

This block is a small register-to-register processor pipeline with three stages. The fetch stage reads one instruction per clock from an internal instruction memory. The second stage decodes the instruction, reads two source registers, selects each ALU operand and computes the result into a result buffer. The third stage writes that buffer into the destination register.

The register write lands one stage after the ALU. An instruction that reads a register written by the instruction directly ahead of it would therefore see a stale value. A bypass multiplexer on each ALU input takes the value from the result buffer instead. With the bypass in place, back-to-back dependent instructions issue without any stall.

A build parameter removes the bypass. In that build, a one-clock interlock holds the fetch and decode stages on every adjacent dependency, and the architectural result is unchanged.

The instruction memory is written through a plain write port, normally while reset is held. A combinational debug read port exposes any register. The write-back stage is visible at the ports.

Top module: `fwd_pipe3`

## Requirements
- R1: An instruction is 16 bits: opcode in [15:12], destination in [11:8], first source in [7:4], second source in [3:0]. The opcodes are: 1 = add, 2 = subtract (first minus second), 3 = and, 4 = or, 5 = xor, 6 = load immediate. A load immediate writes the zero-extended byte [7:0]. Results wrap at DATA_W bits.
- R2: The instruction written at memory address k produces its write-back (wb_en high with wb_rd and wb_data) in the cycle after clock edge k+2, counted from reset release. This holds in the bypass build even across dependencies, so no stall cycle occurs there.
- R3: When the instruction in the write-back stage writes a register that the decoding instruction reads, the decoding instruction takes the value from the result buffer. The two sources are compared separately, so the first source, the second source or both may be bypassed.
- R4: Register 0 always reads as zero, is never written, never appears on wb_rd with wb_en high, and is never a bypass source.
- R5: Opcode 0 (no-op) and the undefined opcodes 7 to 15 write no register, raise no wb_en and never act as a bypass source, whatever their register fields hold.
- R6: With FWD_EN = 0, each instruction that reads the destination of the instruction directly ahead of it is held for exactly one clock. A bubble goes to the write-back stage during that clock. Write-back order and final register contents match the bypass build.
- R7: While reset is high, the fetch address returns to 0, wb_en goes low and all registers clear. Memory writes are accepted during reset.
- R8: dbg_data shows the current contents of register dbg_addr without delay.
- R9: The fetch address stops at the last memory word and then keeps re-issuing that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_we | input | 1 | Instruction memory write strobe |
| imem_addr | input | $clog2(IMEM_DEPTH) | Instruction memory write address |
| imem_wdata | input | 16 | Instruction word to store |
| dbg_addr | input | 4 | Register selected for debug read |
| dbg_data | output | DATA_W | Contents of the selected register |
| wb_en | output | 1 | A register write happens this cycle |
| wb_rd | output | 4 | Destination register being written |
| wb_data | output | DATA_W | Value being written |

## Verification
The hardest case to reach is a no-op or an undefined opcode whose destination field matches a source of the next instruction. That register must still come from the register file, and only a program that plants such a word just ahead of a reader can show it. The same applies to a write aimed at register 0 followed directly by a reader of register 0.

The stimulus is one program that chains these cases with single, double and self dependencies. It runs on a bypass instance and on an interlocked instance side by side. The bench compares each instance's write-back stream, timing and final registers against values derived from the requirements.

// File: rtl/fp3_pkg.sv
package fp3_pkg;
    localparam int INSTR_W = 16;
    localparam int REG_AW  = 4;
    localparam int NREG    = 1 << REG_AW;
    localparam int IMM_W   = 8;

    localparam logic [3:0] OP_NOP = 4'h0;
    localparam logic [3:0] OP_ADD = 4'h1;
    localparam logic [3:0] OP_SUB = 4'h2;
    localparam logic [3:0] OP_AND = 4'h3;
    localparam logic [3:0] OP_OR  = 4'h4;
    localparam logic [3:0] OP_XOR = 4'h5;
    localparam logic [3:0] OP_LDI = 4'h6;

    typedef enum logic [2:0] {
        FN_IMM, FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR
    } alu_fn_e;

    typedef struct packed {
        logic              we;
        logic              use_src;
        alu_fn_e           fn;
        logic [REG_AW-1:0] rd;
        logic [REG_AW-1:0] rs1;
        logic [REG_AW-1:0] rs2;
        logic [IMM_W-1:0]  imm;
    } dec_t;

    function automatic dec_t fp3_decode(input logic [INSTR_W-1:0] w);
        dec_t d;
        d.rd      = w[11:8];
        d.rs1     = w[7:4];
        d.rs2     = w[3:0];
        d.imm     = w[7:0];
        d.fn      = FN_ADD;
        d.we      = 1'b0;
        d.use_src = 1'b0;
        case (w[15:12])
            OP_ADD: begin d.fn = FN_ADD; d.we = 1'b1; d.use_src = 1'b1; end
            OP_SUB: begin d.fn = FN_SUB; d.we = 1'b1; d.use_src = 1'b1; end
            OP_AND: begin d.fn = FN_AND; d.we = 1'b1; d.use_src = 1'b1; end
            OP_OR:  begin d.fn = FN_OR;  d.we = 1'b1; d.use_src = 1'b1; end
            OP_XOR: begin d.fn = FN_XOR; d.we = 1'b1; d.use_src = 1'b1; end
            OP_LDI: begin d.fn = FN_IMM; d.we = 1'b1; end
            default: ;
        endcase
        if (d.rd == '0) d.we = 1'b0;
        return d;
    endfunction
endpackage

// File: rtl/fp3_fetch.sv
module fp3_fetch
    import fp3_pkg::*;
#(
    parameter int IMEM_DEPTH = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          hold,
    input  logic                          wr_en,
    input  logic [$clog2(IMEM_DEPTH)-1:0] wr_addr,
    input  logic [INSTR_W-1:0]            wr_data,
    output logic [INSTR_W-1:0]            ir
);
    localparam int AW = $clog2(IMEM_DEPTH);
    localparam logic [AW-1:0] LAST = AW'(IMEM_DEPTH - 1);

    logic [INSTR_W-1:0] mem [IMEM_DEPTH];
    logic [AW-1:0]      pc;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
            ir <= {OP_NOP, {(INSTR_W-4){1'b0}}};
        end else if (!hold) begin
            ir <= mem[pc];
            if (pc != LAST) pc <= pc + 1'b1;
        end
    end
endmodule

// File: rtl/fp3_regfile.sv
module fp3_regfile
    import fp3_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [REG_AW-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [REG_AW-1:0] ra1,
    input  logic [REG_AW-1:0] ra2,
    input  logic [REG_AW-1:0] ra3,
    output logic [DATA_W-1:0] rd1,
    output logic [DATA_W-1:0] rd2,
    output logic [DATA_W-1:0] rd3
);
    logic [DATA_W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
    assign rd3 = (ra3 == '0) ? '0 : regs[ra3];
endmodule

// File: rtl/fp3_hazard.sv
module fp3_hazard
    import fp3_pkg::*;
#(
    parameter bit FWD_EN = 1'b1
) (
    input  logic              ex_we,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              use_src,
    input  logic [REG_AW-1:0] rs1,
    input  logic [REG_AW-1:0] rs2,
    output logic              fwd1,
    output logic              fwd2,
    output logic              stall
);
    logic hit1, hit2;
    assign hit1 = ex_we && use_src && (rs1 != '0) && (ex_rd == rs1);
    assign hit2 = ex_we && use_src && (rs2 != '0) && (ex_rd == rs2);

    generate
        if (FWD_EN) begin : g_bypass
            assign fwd1  = hit1;
            assign fwd2  = hit2;
            assign stall = 1'b0;
        end else begin : g_interlock
            assign fwd1  = 1'b0;
            assign fwd2  = 1'b0;
            assign stall = hit1 | hit2;
        end
    endgenerate
endmodule

// File: rtl/fp3_alu.sv
module fp3_alu
    import fp3_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_fn_e           fn,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        case (fn)
            FN_ADD:  y = a + b;
            FN_SUB:  y = a - b;
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_XOR:  y = a ^ b;
            default: y = DATA_W'(imm);
        endcase
    end
endmodule

// File: rtl/fwd_pipe3.sv
module fwd_pipe3
    import fp3_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int IMEM_DEPTH = 32,
    parameter bit FWD_EN     = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          imem_we,
    input  logic [$clog2(IMEM_DEPTH)-1:0] imem_addr,
    input  logic [INSTR_W-1:0]            imem_wdata,
    input  logic [REG_AW-1:0]             dbg_addr,
    output logic [DATA_W-1:0]             dbg_data,
    output logic                          wb_en,
    output logic [REG_AW-1:0]             wb_rd,
    output logic [DATA_W-1:0]             wb_data
);
    logic [INSTR_W-1:0] ir;
    dec_t               dec;
    logic [DATA_W-1:0]  rf_a, rf_b, opa, opb, alu_y;
    logic               fwd1, fwd2, stall;

    // result buffer between decode/ALU stage and write-back stage
    logic               ex_we;
    logic [REG_AW-1:0]  ex_rd;
    logic [DATA_W-1:0]  ex_data;

    fp3_fetch #(.IMEM_DEPTH(IMEM_DEPTH)) u_fetch (
        .clk(clk), .rst(rst), .hold(stall),
        .wr_en(imem_we), .wr_addr(imem_addr), .wr_data(imem_wdata),
        .ir(ir)
    );

    assign dec = fp3_decode(ir);

    fp3_regfile #(.DATA_W(DATA_W)) u_rf (
        .clk(clk), .rst(rst),
        .we(ex_we), .waddr(ex_rd), .wdata(ex_data),
        .ra1(dec.rs1), .ra2(dec.rs2), .ra3(dbg_addr),
        .rd1(rf_a), .rd2(rf_b), .rd3(dbg_data)
    );

    fp3_hazard #(.FWD_EN(FWD_EN)) u_hz (
        .ex_we(ex_we), .ex_rd(ex_rd), .use_src(dec.use_src),
        .rs1(dec.rs1), .rs2(dec.rs2),
        .fwd1(fwd1), .fwd2(fwd2), .stall(stall)
    );

    assign opa = fwd1 ? ex_data : rf_a;
    assign opb = fwd2 ? ex_data : rf_b;

    fp3_alu #(.DATA_W(DATA_W)) u_alu (
        .fn(dec.fn), .a(opa), .b(opb), .imm(dec.imm), .y(alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ex_we   <= 1'b0;
            ex_rd   <= '0;
            ex_data <= '0;
        end else if (stall) begin
            ex_we   <= 1'b0;
        end else begin
            ex_we   <= dec.we;
            ex_rd   <= dec.rd;
            ex_data <= alu_y;
        end
    end

    assign wb_en   = ex_we;
    assign wb_rd   = ex_rd;
    assign wb_data = ex_data;
endmodule

// File: rtl/fp3_chk.sv
module fp3_chk
    import fp3_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               wb_en,
    input logic [REG_AW-1:0]  wb_rd,
    input logic [INSTR_W-1:0] ir,
    input logic               stall,
    input logic               fwd1,
    input logic               fwd2
);
    logic op_valid;
    assign op_valid = (ir[15:12] >= OP_ADD) && (ir[15:12] <= OP_LDI);

    p_wb_never_r0_r4: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (wb_rd != '0));

    p_fwd1_source_r3: assert property (@(posedge clk) disable iff (rst)
        fwd1 |-> (wb_en && wb_rd == ir[7:4] && wb_rd != '0));

    p_fwd2_source_r3: assert property (@(posedge clk) disable iff (rst)
        fwd2 |-> (wb_en && wb_rd == ir[3:0] && wb_rd != '0));

    p_nop_silent_r5: assert property (@(posedge clk) disable iff (rst)
        (!stall && !op_valid) |=> !wb_en);

    p_stall_single_r6: assert property (@(posedge clk) disable iff (rst)
        stall |=> !stall);

    p_stall_bubble_r6: assert property (@(posedge clk) disable iff (rst)
        stall |=> !wb_en);

    p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(ir));

    p_reset_clear_r7: assert property (@(posedge clk)
        rst |=> !wb_en);
endmodule

bind fwd_pipe3 fp3_chk u_chk (
    .clk(clk), .rst(rst), .wb_en(wb_en), .wb_rd(wb_rd),
    .ir(ir), .stall(stall), .fwd1(fwd1), .fwd2(fwd2)
);

// File: tb/sim_fwd_pipe3.sv
module sim_fwd_pipe3;
    localparam int DATA_W = 16;
    localparam int DEPTH  = 32;
    localparam int NPROG  = 15;
    localparam int NR     = 16;

    // {instruction[36:21], writes[20], rd[19:16], value[15:0]}
    localparam logic [36:0] PROG [NPROG] = '{
        {16'h6105, 1'b1, 4'd1,  16'h0005},  // R1 load imm
        {16'h6203, 1'b1, 4'd2,  16'h0003},
        {16'h1312, 1'b1, 4'd3,  16'h0008},  // R3 second source bypassed
        {16'h2431, 1'b1, 4'd4,  16'h0003},  // first source bypassed
        {16'h1544, 1'b1, 4'd5,  16'h0006},  // both bypassed
        {16'h5653, 1'b1, 4'd6,  16'h000E},
        {16'h60AA, 1'b0, 4'd0,  16'h0000},  // R4 write to r0 dropped
        {16'h4706, 1'b1, 4'd7,  16'h000E},  // r0 reads zero
        {16'h0733, 1'b0, 4'd0,  16'h0000},  // R5 no-op with rd field 7
        {16'h3877, 1'b1, 4'd8,  16'h000E},
        {16'h2921, 1'b1, 4'd9,  16'hFFFE},  // wrap on subtract
        {16'h1999, 1'b1, 4'd9,  16'hFFFC},  // self dependency
        {16'h6AFF, 1'b1, 4'd10, 16'h00FF},
        {16'hFA00, 1'b0, 4'd0,  16'h0000},  // undefined opcode
        {16'h1BAA, 1'b1, 4'd11, 16'h01FE}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic imem_we = 1'b0;
    logic [4:0]  imem_addr = '0;
    logic [15:0] imem_wdata = '0;
    logic [3:0]  dbg_addr = '0;
    logic [DATA_W-1:0] dbg0, dbg1, wbd0, wbd1;
    logic wbe0, wbe1;
    logic [3:0] wbr0, wbr1;

    always #2.5 clk = ~clk;

    fwd_pipe3 #(.DATA_W(DATA_W), .IMEM_DEPTH(DEPTH), .FWD_EN(1'b1)) u0 (
        .clk(clk), .rst(rst), .imem_we(imem_we), .imem_addr(imem_addr),
        .imem_wdata(imem_wdata), .dbg_addr(dbg_addr), .dbg_data(dbg0),
        .wb_en(wbe0), .wb_rd(wbr0), .wb_data(wbd0));

    fwd_pipe3 #(.DATA_W(DATA_W), .IMEM_DEPTH(DEPTH), .FWD_EN(1'b0)) u1 (
        .clk(clk), .rst(rst), .imem_we(imem_we), .imem_addr(imem_addr),
        .imem_wdata(imem_wdata), .dbg_addr(dbg_addr), .dbg_data(dbg1),
        .wb_en(wbe1), .wb_rd(wbr1), .wb_data(wbd1));

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [3:0]  exp_rd  [NPROG];
    logic [15:0] exp_val [NPROG];
    logic [15:0] model   [NR];
    int nexp = 0;
    int cnt0 = 0, cnt1 = 0, last0 = 0, last1 = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NR; i++) model[i] = '0;
        for (int i = 0; i < NPROG; i++) begin
            if (PROG[i][20]) begin
                exp_rd[nexp]  = PROG[i][19:16];
                exp_val[nexp] = PROG[i][15:0];
                model[PROG[i][19:16]] = PROG[i][15:0];
                nexp++;
            end
        end

        // load memory while reset is held (R7)
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            imem_we    = 1'b1;
            imem_addr  = 5'(a);
            imem_wdata = (a < NPROG) ? PROG[a][36:21] : 16'h0000;
        end
        @(negedge clk);
        imem_we = 1'b0;
        @(negedge clk);

        // reset state R7
        chk(!wbe0 && !wbe1, "R7 wb_en low in reset", {30'd0, wbe1, wbe0}, 0);
        for (int r = 0; r < NR; r++) begin
            dbg_addr = 4'(r);
            #0.5;
            chk(dbg0 == 0 && dbg1 == 0, "R7 register cleared", {dbg1, dbg0}, 0);
        end
        dbg_addr = '0;

        rst = 1'b0;
        for (int e = 1; e <= 40; e++) begin
            @(posedge clk);
            #1;
            if (wbe0) begin
                if (cnt0 < nexp) begin
                    chk(wbr0 == exp_rd[cnt0] && wbd0 == exp_val[cnt0],
                        "R1/R3 bypass write-back", {12'd0, wbr0, wbd0},
                        {12'd0, exp_rd[cnt0], exp_val[cnt0]});
                end else begin
                    chk(1'b0, "R5 extra write (bypass)", {12'd0, wbr0, wbd0}, 0);
                end
                cnt0++;
                last0 = e;
            end
            if (wbe1) begin
                if (cnt1 < nexp) begin
                    chk(wbr1 == exp_rd[cnt1] && wbd1 == exp_val[cnt1],
                        "R6 interlock write-back", {12'd0, wbr1, wbd1},
                        {12'd0, exp_rd[cnt1], exp_val[cnt1]});
                end else begin
                    chk(1'b0, "R5 extra write (interlock)", {12'd0, wbr1, wbd1}, 0);
                end
                cnt1++;
                last1 = e;
            end
        end

        chk(cnt0 == nexp, "R5 write count bypass", cnt0, nexp);
        chk(cnt1 == nexp, "R6 write count interlock", cnt1, nexp);
        chk(last0 == NPROG + 1, "R2 last write edge bypass", last0, NPROG + 1);
        chk(last1 == NPROG + 6, "R6 last write edge interlock", last1, NPROG + 6);

        // final state through debug port R8; also R9 (last word re-issued, no writes)
        @(negedge clk);
        for (int r = 0; r < NR; r++) begin
            dbg_addr = 4'(r);
            #0.5;
            chk(dbg0 == model[r], "R8 final register bypass", dbg0, model[r]);
            chk(dbg1 == model[r], "R6 final register interlock", dbg1, model[r]);
        end
        dbg_addr = 4'd0;
        #0.5;
        chk(dbg0 == 0, "R4 register zero reads zero", dbg0, 0);
        chk(!wbe0 && !wbe1, "R9 idle after end of memory", {30'd0, wbe1, wbe0}, 0);

        // reset again mid-operation R7
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        dbg_addr = 4'd9;
        #0.5;
        chk(dbg0 == 0 && !wbe0, "R7 reset clears state", {dbg0, 15'd0, wbe0}, 0);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule